// File: doc/BRIEF.md
# Outbound Address Translation Viewport Unit

This block maps outbound CPU-side addresses onto bus-side addresses and transaction kinds through a small set of translation windows. Software never reaches a window's registers directly. It writes a selector word first, choosing a direction and a window index. The base, limit, target and control registers that follow then act on whichever window is selected. Only the outbound direction is built. With the inbound direction selected, the window registers are inert.

On the translation side, requests arrive on a valid/ready stream carrying a 64-bit address. The block compares every enabled window against the address in one combinational step and registers the result into a single output stage. A request is accepted only when that output stage is empty, or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response, once presented, holds every field steady until the consumer takes it. A window of a configuration kind turns its target word into a bus/device/function identifier, and the request's offset inside the window is added to that identifier.

Top module: `atu_xlate`

## Requirements
- R1: After reset every window is disabled and every window register reads zero. The selector reads zero, `rsp_valid` is low, and the first request misses.
- R2: The selector word sits at offset 0x900. Bit 31 chooses the direction (1 inbound, 0 outbound) and bit 0 chooses the window index. It reads back as written in those bits.
- R3: For the selected outbound window, the registers are placed as follows and read back what was written: 0x904 holds the 3-bit kind in bits 2:0, and 0x908 holds the enable in bit 31. 0x90C and 0x910 hold the lower and upper base, 0x914 the inclusive last address (base + size − 1), and 0x918 and 0x91C the lower and upper target.
- R4: A request hits a window only when all three of these hold: the window is enabled, `lower base <= addr[31:0] <= limit`, and `addr[63:32]` equals the upper base. One past the limit, one below the base, or a different upper word each give a miss.
- R5: On a hit, `rsp_addr` equals `{upper target, lower target} + (addr[31:0] − lower base)`. `rsp_kind` reports the window's kind code: 0 memory, 2 I/O, 4 configuration type 0, 5 configuration type 1.
- R6: For a configuration window, the lower target carries bus in bits 31:24, device in bits 23:19 and function in bits 18:16. The request's offset into the window is added to that word.
- R7: When both windows hit, window 0 wins, and `rsp_win` reports the winning index.
- R8: On a miss, `rsp_miss` is high, `rsp_addr` equals the request address unchanged, and `rsp_kind` is 0.
- R9: While the selector's inbound bit is set, writes to offsets 0x904–0x91C change no window, and reads of those offsets return zero.
- R10: A register write applies to the very next request accepted after the write cycle, including when a window's kind is switched between configuration and memory.
- R11: A response appears on the cycle after its request is accepted. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every response field stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | CPU-side request address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Translated (or passed-through) address |
| rsp_kind | output | 3 | Transaction kind code of the winning window |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 1 | Index of the winning window |

## Verification
Register reads are combinational, so the bench samples `cfg_rdata` shortly after changing `cfg_addr` in the falling half of the clock. A write is driven across one rising edge and is visible from the next falling edge. Each translation result is due exactly one rising edge after its request is accepted, so the bench presents a request at a falling edge and checks the response at the following falling edge. In the stall case, the bench holds `rsp_ready` low for several cycles, checks that the first response is unchanged and that `req_ready` stays low, then releases and expects the queued request's result one edge later.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_SEL  = 12'h900;
  localparam logic [OFS_W-1:0] OFS_KIND = 12'h904;
  localparam logic [OFS_W-1:0] OFS_ENA  = 12'h908;
  localparam logic [OFS_W-1:0] OFS_BLO  = 12'h90C;
  localparam logic [OFS_W-1:0] OFS_BHI  = 12'h910;
  localparam logic [OFS_W-1:0] OFS_LIM  = 12'h914;
  localparam logic [OFS_W-1:0] OFS_TLO  = 12'h918;
  localparam logic [OFS_W-1:0] OFS_THI  = 12'h91C;

  typedef enum logic [2:0] {
    XK_MEM  = 3'd0,
    XK_IO   = 3'd2,
    XK_CFG0 = 3'd4,
    XK_CFG1 = 3'd5
  } xkind_e;

  typedef struct packed {
    logic              en;
    logic [2:0]        kind;
    logic [WORD_W-1:0] base_lo;
    logic [WORD_W-1:0] base_hi;
    logic [WORD_W-1:0] limit;
    logic [WORD_W-1:0] tgt_lo;
    logic [WORD_W-1:0] tgt_hi;
  } win_t;
endpackage

// File: rtl/atu_win_regs.sv
module atu_win_regs
  import atu_pkg::*;
#(
  parameter int unsigned NWIN = 2,
  localparam int unsigned IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output win_t [NWIN-1:0]      wins
);
  logic          sel_in;
  logic [IW-1:0] sel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_in  <= 1'b0;
      sel_idx <= '0;
    end else if (wr_en && addr == OFS_SEL) begin
      sel_in  <= wdata[WORD_W-1];
      sel_idx <= wdata[IW-1:0];
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic hit_w;
    assign hit_w = wr_en && !sel_in && (sel_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wins[g] <= '0;
      end else if (hit_w) begin
        case (addr)
          OFS_KIND: wins[g].kind    <= wdata[2:0];
          OFS_ENA:  wins[g].en      <= wdata[WORD_W-1];
          OFS_BLO:  wins[g].base_lo <= wdata;
          OFS_BHI:  wins[g].base_hi <= wdata;
          OFS_LIM:  wins[g].limit   <= wdata;
          OFS_TLO:  wins[g].tgt_lo  <= wdata;
          OFS_THI:  wins[g].tgt_hi  <= wdata;
          default:  ;
        endcase
      end
    end
  end

  win_t cur;
  assign cur = wins[sel_idx];

  always_comb begin
    rdata = '0;
    if (addr == OFS_SEL) begin
      rdata[WORD_W-1] = sel_in;
      rdata[IW-1:0]   = sel_idx;
    end else if (!sel_in) begin
      case (addr)
        OFS_KIND: rdata[2:0]        = cur.kind;
        OFS_ENA:  rdata[WORD_W-1]   = cur.en;
        OFS_BLO:  rdata             = cur.base_lo;
        OFS_BHI:  rdata             = cur.base_hi;
        OFS_LIM:  rdata             = cur.limit;
        OFS_TLO:  rdata             = cur.tgt_lo;
        OFS_THI:  rdata             = cur.tgt_hi;
        default:  rdata             = '0;
      endcase
    end
  end

  // R9: an inbound-selected write leaves every window untouched
  assert_inbound_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_in && addr != OFS_SEL) |=> $stable(wins));

  // R1: enables only move through a write to the enable offset
  assert_enable_guarded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == OFS_ENA) |=> $stable(wins[0].en) && $stable(wins[NWIN-1].en));
endmodule

// File: rtl/atu_match.sv
module atu_match
  import atu_pkg::*;
#(
  parameter int unsigned NWIN = 2,
  localparam int unsigned IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  win_t [NWIN-1:0]   wins,
  input  logic [ADDR_W-1:0] addr,
  output logic              any_hit,
  output logic [IW-1:0]     win_idx,
  output logic [ADDR_W-1:0] xaddr,
  output logic [2:0]        xkind
);
  logic [NWIN-1:0] hitv;

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign hitv[g] = wins[g].en &&
                     (addr[WORD_W-1:0] >= wins[g].base_lo) &&
                     (addr[WORD_W-1:0] <= wins[g].limit) &&
                     (addr[ADDR_W-1:WORD_W] == wins[g].base_hi);
  end

  always_comb begin
    win_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hitv[i]) win_idx = IW'(i);
    end
  end

  assign any_hit = |hitv;

  win_t              w;
  logic [WORD_W-1:0] offs;
  assign w    = wins[win_idx];
  assign offs = addr[WORD_W-1:0] - w.base_lo;

  always_comb begin
    if (any_hit) begin
      xaddr = {w.tgt_hi, w.tgt_lo} + {{(ADDR_W-WORD_W){1'b0}}, offs};
      xkind = w.kind;
    end else begin
      xaddr = addr;
      xkind = XK_MEM;
    end
  end
endmodule

// File: rtl/atu_xlate.sv
module atu_xlate
  import atu_pkg::*;
#(
  parameter int unsigned NWIN = 2,
  localparam int unsigned IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [OFS_W-1:0]    cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic [2:0]          rsp_kind,
  output logic                rsp_miss,
  output logic [IW-1:0]       rsp_win
);
  win_t [NWIN-1:0]   wins;
  logic              m_hit;
  logic [IW-1:0]     m_idx;
  logic [ADDR_W-1:0] m_addr;
  logic [2:0]        m_kind;

  atu_win_regs #(.NWIN(NWIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .wins  (wins)
  );

  atu_match #(.NWIN(NWIN)) u_match (
    .wins    (wins),
    .addr    (req_addr),
    .any_hit (m_hit),
    .win_idx (m_idx),
    .xaddr   (m_addr),
    .xkind   (m_kind)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_kind  <= '0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= m_addr;
        rsp_kind <= m_kind;
        rsp_miss <= !m_hit;
        rsp_win  <= m_idx;
      end
    end
  end

  // R11: a stalled response holds all fields
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_kind) && $stable(rsp_miss) && $stable(rsp_win));

  // R11: an accepted request yields a response on the next cycle
  assert_accept_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R8: a miss carries the memory kind code
  assert_miss_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> rsp_kind == 3'd0);
endmodule

// File: tb/atu_xlate_bench.sv
module atu_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_kind;
  logic        rsp_miss;
  logic [0:0]  rsp_win;

  always #(CLK_PERIOD/2) clk = ~clk;

  atu_xlate u_atu_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .rsp_miss(rsp_miss), .rsp_win(rsp_win)
  );

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the window registers
  logic        m_dir = 1'b0;
  logic        m_idx = 1'b0;
  logic        m_en[2];
  logic [2:0]  m_kind[2];
  logic [31:0] m_blo[2], m_bhi[2], m_lim[2], m_tlo[2], m_thi[2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == 12'h900) begin
      m_dir = d[31]; m_idx = d[0];
    end else if (!m_dir) begin
      case (a)
        12'h904: m_kind[m_idx] = d[2:0];
        12'h908: m_en[m_idx]   = d[31];
        12'h90C: m_blo[m_idx]  = d;
        12'h910: m_bhi[m_idx]  = d;
        12'h914: m_lim[m_idx]  = d;
        12'h918: m_tlo[m_idx]  = d;
        12'h91C: m_thi[m_idx]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  function automatic logic win_hit(input int i, input logic [63:0] a);
    return m_en[i] && a[31:0] >= m_blo[i] && a[31:0] <= m_lim[i] && a[63:32] == m_bhi[i];
  endfunction

  task automatic calc(input logic [63:0] a, output logic [63:0] ea, output logic [2:0] ek,
                      output logic em, output logic ew);
    int w;
    w = win_hit(0, a) ? 0 : (win_hit(1, a) ? 1 : -1);
    if (w < 0) begin
      ea = a; ek = 3'd0; em = 1'b1; ew = 1'b0;
    end else begin
      ea = {m_thi[w], m_tlo[w]} + {32'h0, a[31:0] - m_blo[w]};
      ek = m_kind[w]; em = 1'b0; ew = w[0];
    end
  endtask

  task automatic xl(input logic [63:0] a, input string req);
    logic [63:0] ea; logic [2:0] ek; logic em, ew;
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    calc(a, ea, ek, em, ew);
    chk(rsp_valid, {req, " valid"}, {63'h0, rsp_valid}, 64'h1);
    chk(rsp_addr == ea, {req, " addr"}, rsp_addr, ea);
    chk(rsp_kind == ek && rsp_miss == em && rsp_win == ew, {req, " kind/miss/win"},
        {56'h0, rsp_kind, 3'h0, rsp_miss, rsp_win}, {56'h0, ek, 3'h0, em, ew});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] bdf;
    logic [63:0] a1, a2;
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin
      m_en[i] = 0; m_kind[i] = 0; m_blo[i] = 0; m_bhi[i] = 0;
      m_lim[i] = 0; m_tlo[i] = 0; m_thi[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!rsp_valid, "R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    rd_chk(12'h900, 32'h0, "R1 selector reset");
    rd_chk(12'h908, 32'h0, "R1 enable reset");
    rd_chk(12'h90C, 32'h0, "R1 base reset");
    xl(64'h0000_0000_0000_0000, "R1 first request misses");
    xl(64'h1234_5678_9ABC_DEF0, "R8 pass-through");

    // window 0: memory
    wr(12'h900, 32'h0000_0000);
    wr(12'h904, 32'h0);
    wr(12'h90C, 32'h4000_0000);
    wr(12'h910, 32'h0);
    wr(12'h914, 32'h4FFF_FFFF);
    wr(12'h918, 32'h0000_0000);
    wr(12'h91C, 32'h0000_0001);
    wr(12'h908, 32'h8000_0000);
    rd_chk(12'h900, 32'h0, "R2 selector outbound idx0");
    rd_chk(12'h914, 32'h4FFF_FFFF, "R3 limit readback");
    rd_chk(12'h91C, 32'h1, "R3 upper target readback");
    rd_chk(12'h908, 32'h8000_0000, "R3 enable readback");
    xl(64'h0000_0000_4000_1234, "R5 memory hit");
    xl(64'h0000_0000_4FFF_FFFF, "R4 hit at limit");
    xl(64'h0000_0000_5000_0000, "R4 miss past limit");
    xl(64'h0000_0000_3FFF_FFFF, "R4 miss below base");
    xl(64'h0000_0002_4000_0000, "R4 miss upper word");

    // window 1: configuration type 0 overlapping window 0
    bdf = (32'd2 << 24) | (32'd3 << 19) | (32'd1 << 16);
    wr(12'h900, 32'h0000_0001);
    rd_chk(12'h900, 32'h1, "R2 selector idx1");
    wr(12'h904, 32'h4);
    wr(12'h90C, 32'h4000_0000);
    wr(12'h910, 32'h0);
    wr(12'h914, 32'h4000_0FFF);
    wr(12'h918, bdf);
    wr(12'h91C, 32'h0);
    wr(12'h908, 32'h8000_0000);
    rd_chk(12'h904, 32'h4, "R3 kind readback");
    xl(64'h0000_0000_4000_0010, "R7 both hit, window 0 wins");
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h0);
    xl(64'h0000_0000_4000_0010, "R6 config identifier plus offset");
    chk(rsp_addr == {32'h0, bdf + 32'h10}, "R6 bus/dev/fn word", rsp_addr, {32'h0, bdf + 32'h10});

    // R9 inbound selection
    wr(12'h900, 32'h8000_0001);
    rd_chk(12'h900, 32'h8000_0001, "R2 inbound selector readback");
    wr(12'h90C, 32'hDEAD_0000);
    wr(12'h904, 32'h0);
    rd_chk(12'h90C, 32'h0, "R9 inbound read zero");
    xl(64'h0000_0000_4000_0020, "R9 inbound write had no effect");
    wr(12'h900, 32'h0000_0001);
    rd_chk(12'h90C, 32'h4000_0000, "R9 base unchanged");
    rd_chk(12'h904, 32'h4, "R9 kind unchanged");

    // R10 reprogram config -> memory, then back
    wr(12'h904, 32'h0);
    xl(64'h0000_0000_4000_0040, "R10 switch to memory");
    chk(rsp_kind == 3'd0, "R10 kind now memory", {61'h0, rsp_kind}, 64'h0);
    wr(12'h904, 32'h5);
    xl(64'h0000_0000_4000_0040, "R10 switch to config type 1");

    // R11 stall
    a1 = 64'h0000_0000_4000_0100;
    a2 = 64'h0000_0000_7000_0000;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = a1;
    @(negedge clk);
    req_addr = a2;
    repeat (3) @(negedge clk);
    chk(rsp_valid && !req_ready, "R11 stalled valid, not ready", {62'h0, rsp_valid, req_ready}, 64'h2);
    chk(rsp_addr == 64'h0000_0000_0000_0100 + {32'h0, bdf}, "R11 first result held",
        rsp_addr, 64'h0000_0000_0000_0100 + {32'h0, bdf});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_miss && rsp_addr == a2, "R11 queued result one edge later", rsp_addr, a2);
    @(negedge clk);
    chk(!rsp_valid, "R11 drained", {63'h0, rsp_valid}, 64'h0);

    // random programming and traffic
    for (int it = 0; it < 40; it++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] b, s;
        b = $urandom() & 32'h7FFF_F000;
        s = ($urandom() & 32'h000F_FFFF) + 32'h1;
        wr(12'h900, w);
        wr(12'h904, ($urandom() % 2 == 0) ? 32'h0 : 32'h4);
        wr(12'h90C, b);
        wr(12'h910, $urandom() % 2);
        wr(12'h914, b + s - 32'h1);
        wr(12'h918, $urandom());
        wr(12'h91C, $urandom() % 4);
        wr(12'h908, ($urandom() % 4 != 0) ? 32'h8000_0000 : 32'h0);
      end
      for (int k = 0; k < 6; k++) begin
        int w;
        logic [63:0] a;
        w = $urandom() % 2;
        a = {m_bhi[w], m_blo[w] + ($urandom() % 32'h0010_0000)};
        if (k == 5) a = {$urandom(), $urandom()};
        xl(a, "R5 random traffic");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule